// File: doc/BRIEF.md
# Programmable Parallel I/O Port Controller

This block is a host-facing parallel port peripheral. It provides three 8-bit ports, A, B and C, for 24 I/O lines in total. Port C is handled as two independent nibbles. A small host bus reaches three port data registers and a write-only control register. The bus has an active-low select, separate active-low read and write strobes, a 2-bit address and split 8-bit write and read data paths.

The ports fall into two control groups. Group A covers port A and the upper nibble of port C. Group B covers port B and the lower nibble of port C. A control byte with its top bit set defines the direction of every port or nibble and the operating mode of each group. A control byte with its top bit clear forces a single bit of port C's output latch. Only the basic input/output behaviour is implemented. The handshake and bidirectional mode codes are decoded and stored, and they are reported on the group mode outputs. Pad drivers are not inside the block: each port brings out its output value and a per-line output-enable vector.

Writes take effect at the rising clock edge that sees the select and write strobe both low. Read data is combinational while the select and read strobe are both low.

Top module: `pio_top`

## Requirements
- R1: After reset every output-enable line is 0 (all ports are inputs), all output latches are 0, both group mode outputs are 0, and read data is 0x00.
- R2: A write takes effect only at a clock edge where `csN` and `wrN` are both 0. A write strobe with `csN` high, or `csN` low with `wrN` high, changes no latch, direction or mode.
- R3: A control byte with bit 7 = 1 sets the directions, where 1 means input. Bit 4 sets port A, bit 3 the port C upper nibble, bit 1 port B and bit 0 the port C lower nibble. An output-enable line is 1 exactly when its port or nibble is an output.
- R4: Every control byte with bit 7 = 1 clears the output latches of ports A, B and C to 0 at the same edge.
- R5: A control byte with bit 7 = 0 sets port C latch bit n to bit 0 of the byte, where n is bits 3–1 of the byte. Bits 6–4 are ignored. All other latch bits, directions and modes are left unchanged.
- R6: Address 00 selects port A, 01 port B, 10 port C and 11 the control register. A data write to port A, B or C loads that port's output latch, whatever its direction, and the latch appears on the port's output at the next clock.
- R7: A read of port A or B returns its output latch when the port is an output. When the port is an input, it returns the pin value captured at the previous clock edge.
- R8: A read of port C returns, for each nibble on its own, the latch bits when the nibble is an output and the live pin bits (same cycle) when it is an input.
- R9: A read of the control address returns 0x00, and read data is 0x00 whenever `csN` or `rdN` is high.
- R10: Control byte bits 6–5 set the group A mode, where codes 2 and 3 both report mode 2. Bit 2 sets the group B mode, 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low chip select |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe |
| addr | input | 2 | Register select: 00 A, 01 B, 10 C, 11 control |
| wrData | input | 8 | Host write data |
| rdData | output | 8 | Host read data |
| paIn | input | 8 | Port A pin inputs |
| paOut | output | 8 | Port A output latch |
| paOe | output | 8 | Port A output enables |
| pbIn | input | 8 | Port B pin inputs |
| pbOut | output | 8 | Port B output latch |
| pbOe | output | 8 | Port B output enables |
| pcIn | input | 8 | Port C pin inputs |
| pcOut | output | 8 | Port C output latch |
| pcOe | output | 8 | Port C output enables |
| grpAMode | output | 2 | Group A mode (0, 1 or 2) |
| grpBMode | output | 1 | Group B mode (0 or 1) |

## Verification
The bench sweeps all 128 mode-definition bytes and checks each one for direction bits, mode reporting and latch clearing. A design that swapped the two port C nibble direction bits, or read the direction polarity backwards, would show the wrong enables or return latch data where pin data was expected. It also walks the bit set/reset command over every port C bit with stray upper bits present. A design that decoded bits 6–4, clobbered neighbouring bits or disturbed the directions would be exposed there. Further checks cover strobes without a valid select, reads of the control address, and the one-cycle capture delay of ports A and B against the live reads of port C.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int NIB_W  = 4;
  localparam int PORT_W = 2 * NIB_W;
  localparam int NUM_NIB = PORT_W / NIB_W;
  localparam int SEL_W  = $clog2(PORT_W);
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_A   = 2'b00,
    SEL_B   = 2'b01,
    SEL_C   = 2'b10,
    SEL_CTL = 2'b11
  } portSel_e;

  // Stored configuration, bit order matches control byte bits 6..0
  typedef struct packed {
    logic [1:0] modeA;
    logic       dirA;
    logic       dirCHi;
    logic       modeB;
    logic       dirB;
    logic       dirCLo;
  } modeCfg_t;

  localparam modeCfg_t CFG_RESET = '{modeA: 2'b00, dirA: 1'b1, dirCHi: 1'b1,
                                     modeB: 1'b0, dirB: 1'b1, dirCLo: 1'b1};

  // Strobes from control to datapath
  typedef struct packed {
    logic     ldA;
    logic     ldB;
    logic     ldC;
    logic     ldMode;
    logic     ldBit;
    logic     rdEn;
    portSel_e rdSel;
  } busStrb_t;
endpackage

// File: rtl/pio_bus_ctrl.sv
module pio_bus_ctrl
  import pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PORT_W-1:0] wrData,
  output busStrb_t          strb,
  output modeCfg_t          cfg,
  output logic [1:0]        grpAMode,
  output logic              grpBMode
);
  logic wrHit;
  logic rdHit;
  logic ctlHit;
  logic isModeWord;

  always_comb begin
    wrHit      = !csN && !wrN;
    rdHit      = !csN && !rdN;
    ctlHit     = wrHit && (portSel_e'(addr) == SEL_CTL);
    isModeWord = wrData[PORT_W-1];
    strb.ldA    = wrHit && (portSel_e'(addr) == SEL_A);
    strb.ldB    = wrHit && (portSel_e'(addr) == SEL_B);
    strb.ldC    = wrHit && (portSel_e'(addr) == SEL_C);
    strb.ldMode = ctlHit && isModeWord;
    strb.ldBit  = ctlHit && !isModeWord;
    strb.rdEn   = rdHit;
    strb.rdSel  = portSel_e'(addr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= CFG_RESET;
    end else if (strb.ldMode) begin
      cfg <= modeCfg_t'(wrData[PORT_W-2:0]);
    end
  end

  // Codes 2 and 3 both mean the bidirectional mode
  always_comb begin
    grpAMode = cfg.modeA[1] ? 2'd2 : cfg.modeA;
    grpBMode = cfg.modeB;
  end
endmodule

// File: rtl/pio_datapath.sv
module pio_datapath
  import pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  busStrb_t          strb,
  input  modeCfg_t          cfg,
  input  logic [PORT_W-1:0] wrData,
  input  logic [PORT_W-1:0] paIn,
  input  logic [PORT_W-1:0] pbIn,
  input  logic [PORT_W-1:0] pcIn,
  output logic [PORT_W-1:0] paOut,
  output logic [PORT_W-1:0] pbOut,
  output logic [PORT_W-1:0] pcOut,
  output logic [PORT_W-1:0] paOe,
  output logic [PORT_W-1:0] pbOe,
  output logic [PORT_W-1:0] pcOe,
  output logic [PORT_W-1:0] rdData
);
  logic [PORT_W-1:0] latA, latB, latC;
  logic [PORT_W-1:0] capA, capB;
  logic [PORT_W-1:0] viewA, viewB, viewC;
  logic [SEL_W-1:0]  bitIdx;

  assign bitIdx = wrData[SEL_W:1];

  // Output latches
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latA <= '0;
      latB <= '0;
      latC <= '0;
    end else if (strb.ldMode) begin
      latA <= '0;
      latB <= '0;
      latC <= '0;
    end else begin
      if (strb.ldA) latA <= wrData;
      if (strb.ldB) latB <= wrData;
      if (strb.ldC) begin
        latC <= wrData;
      end else if (strb.ldBit) begin
        latC[bitIdx] <= wrData[0];
      end
    end
  end

  // Input capture registers for ports A and B
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capA <= '0;
      capB <= '0;
    end else begin
      capA <= paIn;
      capB <= pbIn;
    end
  end

  assign paOut = latA;
  assign pbOut = latB;
  assign pcOut = latC;
  assign paOe  = {PORT_W{~cfg.dirA}};
  assign pbOe  = {PORT_W{~cfg.dirB}};
  assign viewA = cfg.dirA ? capA : latA;
  assign viewB = cfg.dirB ? capB : latB;

  // Per-nibble direction of port C
  for (genvar g = 0; g < NUM_NIB; g++) begin : g_cnib
    logic nibIn;
    assign nibIn = (g == 0) ? cfg.dirCLo : cfg.dirCHi;
    assign pcOe[g*NIB_W +: NIB_W]  = {NIB_W{~nibIn}};
    assign viewC[g*NIB_W +: NIB_W] = nibIn ? pcIn[g*NIB_W +: NIB_W]
                                           : latC[g*NIB_W +: NIB_W];
  end

  always_comb begin
    rdData = '0;
    if (strb.rdEn) begin
      unique case (strb.rdSel)
        SEL_A:   rdData = viewA;
        SEL_B:   rdData = viewB;
        SEL_C:   rdData = viewC;
        default: rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/pio_top.sv
module pio_top
  import pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [1:0]        addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic [7:0]        paIn,
  output logic [7:0]        paOut,
  output logic [7:0]        paOe,
  input  logic [7:0]        pbIn,
  output logic [7:0]        pbOut,
  output logic [7:0]        pbOe,
  input  logic [7:0]        pcIn,
  output logic [7:0]        pcOut,
  output logic [7:0]        pcOe,
  output logic [1:0]        grpAMode,
  output logic              grpBMode
);
  busStrb_t strb;
  modeCfg_t cfg;

  pio_bus_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .csN(csN), .rdN(rdN), .wrN(wrN),
    .addr(addr), .wrData(wrData), .strb(strb), .cfg(cfg),
    .grpAMode(grpAMode), .grpBMode(grpBMode)
  );

  pio_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .cfg(cfg), .wrData(wrData),
    .paIn(paIn), .pbIn(pbIn), .pcIn(pcIn),
    .paOut(paOut), .pbOut(pbOut), .pcOut(pcOut),
    .paOe(paOe), .pbOe(pbOe), .pcOe(pcOe), .rdData(rdData)
  );
endmodule

// File: rtl/pio_chk.sv
module pio_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       csN,
  input logic       rdN,
  input logic       wrN,
  input logic [1:0] addr,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic [7:0] paOut,
  input logic [7:0] pbOut,
  input logic [7:0] pcOut,
  input logic [7:0] paOe,
  input logic [7:0] pbOe,
  input logic [7:0] pcOe,
  input logic [1:0] grpAMode,
  input logic       grpBMode
);
  logic pastOk;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pastOk <= 1'b0;
    else        pastOk <= 1'b1;
  end

  logic modeWr, bitWr;
  assign modeWr = !csN && !wrN && addr == 2'b11 && wrData[7];
  assign bitWr  = !csN && !wrN && addr == 2'b11 && !wrData[7];

  p_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pastOk && csN) |=> ($stable(paOut) && $stable(pbOut) && $stable(pcOut)
                         && $stable(paOe) && $stable(pcOe)));

  p_nibble_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(pcOe[7:4]) inside {0, 4}) && ($countones(pcOe[3:0]) inside {0, 4}));

  p_mode_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pastOk && modeWr) |=> (paOut == 8'h00 && pbOut == 8'h00 && pcOut == 8'h00));

  p_bit_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pastOk && bitWr) |=> (pcOut[$past(wrData[3:1])] == $past(wrData[0])));

  p_bit_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pastOk && bitWr) |=> ($stable(paOe) && $stable(pbOe) && $stable(pcOe)
                           && $stable(grpAMode) && $stable(grpBMode)));

  p_ctl_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!csN && !rdN && addr == 2'b11) |-> rdData == 8'h00);

  p_idle_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (csN || rdN) |-> rdData == 8'h00);

  p_mode_two_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pastOk && modeWr && wrData[6]) |=> grpAMode == 2'd2);
endmodule

bind pio_top pio_chk u_chk (.*);

// File: tb/tb_pio_top.sv
module tb_pio_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [1:0] addr = 2'b00;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic [7:0] paIn = 8'h00, pbIn = 8'h00, pcIn = 8'h00;
  logic [7:0] paOut, pbOut, pcOut, paOe, pbOe, pcOe;
  logic [1:0] grpAMode;
  logic       grpBMode;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  pio_top dut (
    .clk(clk), .rst_n(rst_n), .csN(csN), .rdN(rdN), .wrN(wrN),
    .addr(addr), .wrData(wrData), .rdData(rdData),
    .paIn(paIn), .paOut(paOut), .paOe(paOe),
    .pbIn(pbIn), .pbOut(pbOut), .pbOe(pbOe),
    .pcIn(pcIn), .pcOut(pcOut), .pcOe(pcOe),
    .grpAMode(grpAMode), .grpBMode(grpBMode)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; csN = 1'b0; wrN = 1'b0;
    @(negedge clk);
    csN = 1'b1; wrN = 1'b1;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; csN = 1'b0; rdN = 1'b0;
    #1 d = rdData;
    csN = 1'b1; rdN = 1'b1;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] expC;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 paOe", paOe, 0); check("R1 pbOe", pbOe, 0); check("R1 pcOe", pcOe, 0);
    check("R1 outs", {paOut, pbOut, pcOut}, 0);
    check("R1 modes", {grpAMode, grpBMode}, 0);
    check("R9 idle rd", rdData, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3/R4/R6/R7/R8/R10 sweep of every mode byte
    for (int w = 0; w < 128; w++) begin
      logic [7:0] mw, la, lb, lc, pa, pb, pc;
      mw = 8'h80 | 8'(w);
      busWrite(2'b00, 8'h5A); busWrite(2'b01, 8'hA5); busWrite(2'b10, 8'h3C);
      if (w < 4) begin
        check("R6 paOut", paOut, 8'h5A); check("R6 pbOut", pbOut, 8'hA5);
        check("R6 pcOut", pcOut, 8'h3C);
      end
      busWrite(2'b11, mw);
      check("R4 cleared", {paOut, pbOut, pcOut}, 0);
      check("R3 paOe", paOe, mw[4] ? 0 : 8'hFF);
      check("R3 pbOe", pbOe, mw[1] ? 0 : 8'hFF);
      check("R3 pcOe", pcOe, {mw[3] ? 4'h0 : 4'hF, mw[0] ? 4'h0 : 4'hF});
      check("R10 modeA", grpAMode, mw[6] ? 2 : int'(mw[6:5]));
      check("R10 modeB", grpBMode, mw[2]);
      la = mw ^ 8'h33; lb = mw ^ 8'h0F; lc = mw ^ 8'hE1;
      pa = ~mw; pb = mw ^ 8'h96; pc = 8'(w * 37 + 11);
      paIn = pa; pbIn = pb;
      busWrite(2'b00, la); busWrite(2'b01, lb); busWrite(2'b10, lc);
      pcIn = pc;
      busRead(2'b00, rd); check("R7 read A", rd, mw[4] ? pa : la);
      busRead(2'b01, rd); check("R7 read B", rd, mw[1] ? pb : lb);
      busRead(2'b10, rd);
      check("R8 read C", rd, {mw[3] ? pc[7:4] : lc[7:4], mw[0] ? pc[3:0] : lc[3:0]});
      busRead(2'b11, rd); check("R9 ctl read", rd, 0);
    end

    // R7 capture delay: pin change is seen only after a clock edge
    busWrite(2'b11, 8'h9B);
    @(negedge clk); paIn = 8'h11; @(negedge clk); paIn = 8'h22;
    addr = 2'b00; csN = 1'b0; rdN = 1'b0; #1 rd = rdData; csN = 1'b1; rdN = 1'b1;
    check("R7 capture lag", rd, 8'h11);
    pcIn = 8'h11; @(negedge clk); pcIn = 8'h7E;
    addr = 2'b10; csN = 1'b0; rdN = 1'b0; #1 rd = rdData; csN = 1'b1; rdN = 1'b1;
    check("R8 live C", rd, 8'h7E);

    // R2 strobes without a valid select
    busWrite(2'b11, 8'h80);
    busWrite(2'b00, 8'h42);
    @(negedge clk); addr = 2'b00; wrData = 8'hFF; csN = 1'b1; wrN = 1'b0;
    @(negedge clk); addr = 2'b11; wrData = 8'h9B;
    @(negedge clk); addr = 2'b01; csN = 1'b0; wrN = 1'b1; wrData = 8'h77;
    @(negedge clk); csN = 1'b1;
    check("R2 paOut kept", paOut, 8'h42);
    check("R2 pbOut kept", pbOut, 8'h00);
    check("R2 oe kept", {paOe, pbOe, pcOe}, 24'hFFFFFF);

    // R5 bit set/reset walk, with bits 6-4 set to junk
    busWrite(2'b11, 8'hA0);
    expC = 8'h00;
    for (int n = 0; n < 8; n++) begin
      busWrite(2'b11, 8'h70 | 8'(n << 1) | 8'h01);
      expC[n] = 1'b1;
      check("R5 set", pcOut, expC);
    end
    for (int n = 0; n < 8; n += 2) begin
      busWrite(2'b11, 8'h50 | 8'(n << 1));
      expC[n] = 1'b0;
      check("R5 clear", pcOut, expC);
    end
    check("R5 oe kept", {paOe, pbOe, pcOe}, 24'hFFFFFF);
    check("R5 mode kept", {grpAMode, grpBMode}, 3'b010);
    check("R5 A kept", paOut, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule